// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an 8-bit general-purpose I/O data port on a simple zero-wait-state register bus (psel/penable/pwrite). A 256-word window of word-aligned addresses is folded onto one physical output latch. Byte address bits [9:2] of each access form a per-bit mask. A single bus store through any alias updates exactly the pins chosen by that mask and leaves every other pin alone. Software can therefore change any subset of pins atomically, with no read-modify-write sequence that an interrupt or another task could split.

Reads through the same window return the current pin value gated by the mask. For an output pin the pin value is its driven latch bit. For an input pin it is the externally applied level after a two-flop synchroniser. A separate direction register selects, per pin, whether the latch drives the pad. Input pins keep their latch, and masked writes still update it, so a pin can be preloaded before it is turned into an output.

Top module: `gpio_alias_port`

## Requirements
- R1: While reset is asserted and after it, the output latch, the direction register and the synchroniser are all zero: pins_out = 0x00 and pins_oe = 0x00.
- R2: An access-phase write to byte address 0x000 to 0x3FC (bits [11:10] = 0, bits [1:0] = 0) with mask m = paddr[9:2] sets latch bit i to pwdata[i] where m[i] = 1 and keeps latch bit i where m[i] = 0.
- R3: A write to the all-zeros alias 0x000 changes no latch bit, and a read of 0x000 returns 0.
- R4: The all-ones alias 0x3FC writes all eight latch bits from pwdata[7:0] and reads all eight pin values.
- R5: A read in the data window returns prdata[7:0] = pin value AND m, and prdata[31:8] is always 0.
- R6: A write to byte address 0x400 loads pwdata[7:0] into the direction register, where bit i = 1 means output. pins_oe equals that register, and pins_out always shows the latch, including bits that are inputs.
- R7: For an input pin (direction bit 0), a change on pins_in is not visible in read data one rising edge after it is applied. It is visible after the second rising edge.
- R8: For an output pin (direction bit 1), read data shows the latch bit and ignores pins_in.
- R9: State changes only on a rising edge with psel, penable and pwrite all 1. A setup phase (penable = 0) or a read access leaves pins_out and pins_oe unchanged.
- R10: Writes to any address other than the data window and 0x400 are ignored: 0x404, 0x800 and above, aliases with bits [11:10] set, and addresses with bits [1:0] nonzero. Reads of such addresses return 0.
- R11: A read of 0x400 returns the direction register in prdata[7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase qualifier |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address; bits [9:2] carry the pin mask in the data window |
| pwdata | input | 32 | Write data; bits [7:0] are used |
| prdata | output | 32 | Read data, valid while psel = 1 and pwrite = 0 |
| pins_in | input | 8 | External pin levels, asynchronous |
| pins_out | output | 8 | Output latch value |
| pins_oe | output | 8 | Per-pin drive enable |

## Verification
The masked store is tried with the full mask, the empty mask, a contiguous low nibble and a lone single bit. Against a latch holding a mixed pattern, these separate "mask gates the write" from "data is written whole" and from "mask ignored". Reads use masks that cover only part of a mixed input/output direction setting. This tells whether read data comes from the latch or from the synchronised pins, and whether unmasked bits are cleared. Addresses just outside the window, one above the direction register, and with the upper address bits set show whether the decode wraps the aliases. A held read across a pin change separates a two-stage synchroniser from a one-stage one.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

  // Which register an address selects.
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_DATA = 2'd1,
    RGN_DIR  = 2'd2
  } rgn_e;

endpackage

// File: rtl/gpio_alias_rst.sv
// Reset conditioner: asserts at once, releases after STAGES clean edges.
module gpio_alias_rst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_alias_decode.sv
// Address decode: region select and per-bit mask from address lines.
module gpio_alias_decode
  import gpio_alias_pkg::*;
#(
  parameter int              NBITS   = 8,
  parameter int              ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] DIR_OFF = 12'h400
) (
  input  logic [ADDR_W-1:0] paddr,
  output rgn_e              rgn,
  output logic [NBITS-1:0]  mask
);

  localparam int WIN_HI = NBITS + 2;   // first address bit above the window

  logic aligned;
  logic in_window;
  logic is_dir;

  assign aligned   = (paddr[1:0] == 2'b00);
  assign in_window = aligned && (paddr[ADDR_W-1:WIN_HI] == '0);
  assign is_dir    = (paddr == DIR_OFF);
  assign mask      = paddr[WIN_HI-1:2];

  always_comb begin
    if (in_window)   rgn = RGN_DATA;
    else if (is_dir) rgn = RGN_DIR;
    else             rgn = RGN_NONE;
  end

endmodule

// File: rtl/gpio_alias_sync.sv
// Multi-flop synchroniser for the input pins.
module gpio_alias_sync #(
  parameter int NBITS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] din,
  output logic [NBITS-1:0] dout
);

  logic [STAGES-1:0][NBITS-1:0] stg_q;
  logic [STAGES-1:0][NBITS-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_alias_regs.sv
// Output latch with per-bit masked update, and the direction register.
module gpio_alias_regs #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_we,
  input  logic             dir_we,
  input  logic [NBITS-1:0] mask,
  input  logic [NBITS-1:0] wdata,
  output logic [NBITS-1:0] lat_q,
  output logic [NBITS-1:0] dir_q
);

  logic [NBITS-1:0] lat_d;
  logic [NBITS-1:0] lat_en;

  // Per-bit enable: only masked bits of a data-window write load.
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign lat_en[i] = lat_we & mask[i];
    assign lat_d[i]  = lat_en[i] ? wdata[i] : lat_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= wdata;
  end

endmodule

// File: rtl/gpio_alias_port.sv
// Address-masked GPIO data port, top level.
module gpio_alias_port
  import gpio_alias_pkg::*;
#(
  parameter int                NBITS   = 8,
  parameter int                ADDR_W  = 12,
  parameter int                DATA_W  = 32,
  parameter int                SYNC_N  = 2,
  parameter logic [ADDR_W-1:0] DIR_OFF = 12'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [NBITS-1:0]  pins_in,
  output logic [NBITS-1:0]  pins_out,
  output logic [NBITS-1:0]  pins_oe
);

  logic             rst_n_i;
  rgn_e             rgn;
  logic [NBITS-1:0] mask;
  logic [NBITS-1:0] in_sync;
  logic [NBITS-1:0] lat_q;
  logic [NBITS-1:0] dir_q;
  logic [NBITS-1:0] pin_val;
  logic             wr_acc;
  logic             unused_ok;

  assign unused_ok = ^pwdata[DATA_W-1:NBITS];

  gpio_alias_rst #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  gpio_alias_decode #(.NBITS(NBITS), .ADDR_W(ADDR_W), .DIR_OFF(DIR_OFF)) u_dec (
    .paddr (paddr),
    .rgn   (rgn),
    .mask  (mask)
  );

  gpio_alias_sync #(.NBITS(NBITS), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .din   (pins_in),
    .dout  (in_sync)
  );

  assign wr_acc = psel & penable & pwrite;

  gpio_alias_regs #(.NBITS(NBITS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .lat_we (wr_acc && (rgn == RGN_DATA)),
    .dir_we (wr_acc && (rgn == RGN_DIR)),
    .mask   (mask),
    .wdata  (pwdata[NBITS-1:0]),
    .lat_q  (lat_q),
    .dir_q  (dir_q)
  );

  // Output bits read their latch, input bits read the synchronised pin.
  assign pin_val = (dir_q & lat_q) | (~dir_q & in_sync);

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (rgn)
        RGN_DATA: prdata[NBITS-1:0] = pin_val & mask;
        RGN_DIR:  prdata[NBITS-1:0] = dir_q;
        default:  prdata = '0;
      endcase
    end
  end

  assign pins_out = lat_q;
  assign pins_oe  = dir_q;

endmodule

// File: rtl/gpio_alias_chk.sv
// Port-level properties of the masked GPIO port.
module gpio_alias_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [7:0]  wdata,
  input logic [31:0] prdata,
  input logic [7:0]  pins_out,
  input logic [7:0]  pins_oe
);

  logic hit_win;
  logic hit_dir;
  logic wr;
  logic [7:0] amask;

  assign hit_win = (paddr[11:10] == 2'b00) && (paddr[1:0] == 2'b00);
  assign hit_dir = (paddr == 12'h400);
  assign wr      = psel && penable && pwrite;
  assign amask   = paddr[9:2];

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(pins_out) && $stable(pins_oe)));

  p_mask_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_win) |=> ((pins_out & ~$past(amask)) == ($past(pins_out) & ~$past(amask))));

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_win) |=> ((pins_out & $past(amask)) == ($past(wdata) & $past(amask))));

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prdata[31:8] == 24'h0);

  p_read_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && hit_win) |-> ((prdata[7:0] & ~amask) == 8'h00));

  p_dir_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_dir) |=> (pins_oe == $past(wdata)));

  p_outside_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !hit_win && !hit_dir) |-> (prdata == 32'h0));

  p_outside_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit_win && !hit_dir) |=> ($stable(pins_out) && $stable(pins_oe)));

endmodule

bind gpio_alias_port gpio_alias_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .wdata    (pwdata[7:0]),
  .prdata   (prdata),
  .pins_out (pins_out),
  .pins_oe  (pins_oe)
);

// File: tb/gpio_alias_port_bench.sv
module gpio_alias_port_bench;

  logic        clk;
  logic        rst_n;
  logic        psel;
  logic        penable;
  logic        pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic [7:0]  pins_in;
  logic [7:0]  pins_out;
  logic [7:0]  pins_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  gpio_alias_port u_gpio_alias_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .pins_in  (pins_in),
    .pins_out (pins_out),
    .pins_oe  (pins_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // Vector: [33:32] kind (0 write/check pins_out, 1 read/check prdata,
  // 2 write/check pins_oe), [31:20] addr, [19:12] data, [11:4] expected,
  // [3:0] requirement number. pins_in is held at 0x3C.
  localparam int NV = 16;
  localparam logic [33:0] VEC [NV] = '{
    {2'd2, 12'h400, 8'hFF, 8'hFF, 4'd6},   // R6 all outputs
    {2'd0, 12'h3FC, 8'h5A, 8'h5A, 4'd4},   // R4 full write
    {2'd0, 12'h03C, 8'hFF, 8'h5F, 4'd2},   // R2 low nibble mask
    {2'd0, 12'h100, 8'h00, 8'h1F, 4'd2},   // R2 single bit 6
    {2'd0, 12'h000, 8'hFF, 8'h1F, 4'd3},   // R3 empty mask
    {2'd1, 12'h3FC, 8'h00, 8'h1F, 4'd8},   // R8 latch, not pins_in
    {2'd1, 12'h3C0, 8'h00, 8'h10, 4'd5},   // R5 high nibble mask
    {2'd1, 12'h000, 8'h00, 8'h00, 4'd3},   // R3 read zero
    {2'd2, 12'h400, 8'h0F, 8'h0F, 4'd6},   // R6 high nibble inputs
    {2'd0, 12'h3FC, 8'hAA, 8'hAA, 4'd6},   // R6 latch updated on inputs
    {2'd1, 12'h3FC, 8'h00, 8'h3A, 4'd7},   // R7 mixed: 3C hi, AA lo
    {2'd1, 12'h400, 8'h00, 8'h0F, 4'd11},  // R11 direction readback
    {2'd0, 12'h404, 8'h00, 8'hAA, 4'd10},  // R10 above direction reg
    {2'd1, 12'h404, 8'h00, 8'h00, 4'd10},  // R10
    {2'd1, 12'h800, 8'h00, 8'h00, 4'd10},  // R10
    {2'd0, 12'h83C, 8'h00, 8'hAA, 4'd10}   // R10 no wrap of aliases
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // All tasks begin and end just after a falling edge.
  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = {24'h0, d};
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a; pwdata = '0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pins_in = 8'h3C;
    repeat (3) @(negedge clk);
    #1;
    check(pins_out == 8'h00, "R1 out in reset", {24'h0, pins_out}, 32'h0);
    check(pins_oe == 8'h00, "R1 oe in reset", {24'h0, pins_oe}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(pins_out == 8'h00, "R1 out after reset", {24'h0, pins_out}, 32'h0);
    bus_read(12'h400, rd);
    check(rd == 32'h0, "R1 direction after reset", rd, 32'h0);
    bus_read(12'h3FC, rd);
    check(rd == 32'h3C, "R1 all inputs after reset", rd, 32'h3C);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [11:0] a;
      logic [7:0]  d;
      logic [7:0]  e;
      string       rq;
      k  = VEC[i][33:32];
      a  = VEC[i][31:20];
      d  = VEC[i][19:12];
      e  = VEC[i][11:4];
      rq = $sformatf("R%0d vec %0d", VEC[i][3:0], i);
      if (k == 2'd1) begin
        bus_read(a, rd);
        check(rd == {24'h0, e}, rq, rd, {24'h0, e});
      end else begin
        bus_write(a, d);
        if (k == 2'd0) check(pins_out == e, rq, {24'h0, pins_out}, {24'h0, e});
        else           check(pins_oe == e, rq, {24'h0, pins_oe}, {24'h0, e});
      end
    end

    // R9: setup phase only, held for two edges, must not write.
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h3FC; pwdata = 32'h0;
    repeat (2) @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    check(pins_out == 8'hAA, "R9 setup only", {24'h0, pins_out}, 32'hAA);
    // R9: a read access carrying write data must not write.
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = 12'h3FC; pwdata = 32'h55;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
    check(pins_out == 8'hAA, "R9 read access", {24'h0, pins_out}, 32'hAA);
    // R10: misaligned address in the window is ignored.
    bus_write(12'h3FD, 8'h00);
    check(pins_out == 8'hAA, "R10 misaligned", {24'h0, pins_out}, 32'hAA);

    // R7: two-edge latency on input bits (dir = 0x0F, latch = 0xAA).
    psel = 1'b1; pwrite = 1'b0; penable = 1'b1; paddr = 12'h3FC;
    pins_in = 8'hC3;
    @(negedge clk); #1;
    check(prdata == 32'h3A, "R7 one edge", prdata, 32'h3A);
    @(negedge clk); #1;
    check(prdata == 32'hCA, "R7 two edges", prdata, 32'hCA);
    psel = 1'b0; penable = 1'b0;
    @(negedge clk);

    // R1: reset mid-run clears everything at once.
    rst_n = 1'b0;
    #1;
    check(pins_out == 8'h00, "R1 re-reset out", {24'h0, pins_out}, 32'h0);
    check(pins_oe == 8'h00, "R1 re-reset oe", {24'h0, pins_oe}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule